// File: doc/BRIEF.md
# Thresholded Qualified Event Counter

This block is one performance-monitoring counter. Each clock it receives a small unsigned number saying how many occurrences of one event happened in that cycle, anywhere from zero up to the event's per-cycle maximum. A programmable threshold decides how that number is accumulated. At threshold zero the whole count is added. Above zero the counter moves by exactly one, and only in cycles whose count is strictly larger than the threshold. This lets software ask either "how many occurrences in total" or "how many cycles were busier than n".

Each cycle is also qualified before anything is added. The qualifiers are a one-bit instruction-set mode with a three-way selector, a privilege level checked against a per-level mask, an address-range match flag that can be inverted, and an opcode match flag. The matchers that produce these flags live outside the block. A global freeze input stops accumulation.

Software writes configuration through a three-entry register port. It can preload the 64-bit counter. When the counter wraps past all ones it raises a sticky flag and a one-cycle interrupt pulse, so a preload of 2^64 minus P gives a sampling period of P.

Top module: `qec_top`

## Requirements
- R1: After reset the counter, `ovf_flag` and `ovf_irq` are all 0. The configuration resets to threshold 0, mode selector "any", range and opcode qualifiers off, and all privilege-mask bits set.
- R2: With threshold 0, a qualified cycle adds the full `evt_cnt` to the counter.
- R3: With threshold t > 0, a qualified cycle adds 1 when `evt_cnt` > t and adds 0 otherwise.
- R4: The configuration register is `wr_addr` = 0, with these fields: threshold in bits [7:0], mode selector in [9:8], range invert in [10], range enable in [11], opcode enable in [12], and privilege mask in [19:16]. A threshold written above MAX_INC-1 is stored as MAX_INC-1.
- R5: An `evt_cnt` value above MAX_INC is treated as MAX_INC.
- R6: Mode selector 1 counts only while `isa_mode` is 1, selector 2 counts only while it is 0, and selectors 0 and 3 count in both states.
- R7: A cycle counts only when privilege-mask bit [`priv_lvl`] is 1.
- R8: With range enable set, a cycle counts only when `range_hit` XOR range-invert is 1. With range enable clear, `range_hit` is ignored.
- R9: With opcode enable set, a cycle counts only when `opc_hit` is 1. With opcode enable clear, `opc_hit` is ignored.
- R10: While `freeze` is 1 the counter does not change.
- R11: A configuration write governs counting from the cycle after the write. The cycle in which the write is presented is still judged by the old configuration.
- R12: A write to `wr_addr` = 1 loads `wr_data` into the counter. The load takes priority over any accumulation in that cycle.
- R13: When an addition carries out of the top bit, `ovf_flag` is set and `ovf_irq` is 1 for exactly that one cycle. A write to `wr_addr` = 2 clears `ovf_flag`.
- R14: If SUP_RANGE or SUP_OPC is 0, the matching enable bit is ignored. If MAX_INC = 1, the threshold is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 configuration, 1 counter load, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| freeze | input | 1 | Stops accumulation |
| evt_cnt | input | INC_W | Event occurrences in this cycle |
| isa_mode | input | 1 | Instruction-set mode bit |
| priv_lvl | input | PRIV_W | Current privilege level |
| range_hit | input | 1 | Address-range matcher flag |
| opc_hit | input | 1 | Opcode matcher flag |
| cnt | output | CNT_W | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | One-cycle overflow pulse |

## Verification
Every result comes from a single register stage, with these timings:
- The counter, the overflow flag and the overflow pulse all reflect the inputs of a cycle right after that cycle's rising edge.
- A configuration write is judged only from the following cycle onward.

The bench works to this timing:
- It changes inputs on the falling edge and reads outputs on the next falling edge, so each sample shows exactly one edge's effect.
- It compares the counter difference across that one edge with a value computed arithmetically.
- For the write-timing rule it presents an event in the write cycle itself and expects the old configuration to apply there.

// File: rtl/qec_pkg.sv
`timescale 1ns/1ps
package qec_pkg;
  // privilege levels and configuration field layout
  localparam int PRIV_N  = 4;
  localparam int THR_W   = 8;
  localparam int THR_LSB = 0;
  localparam int ISA_LSB = 8;
  localparam int INV_BIT = 10;
  localparam int REN_BIT = 11;
  localparam int OEN_BIT = 12;
  localparam int PM_LSB  = 16;

  // register select codes
  localparam int REG_CFG = 0;
  localparam int REG_CNT = 1;
  localparam int REG_CLR = 2;

  typedef enum logic [1:0] {
    ISA_ANY  = 2'd0,
    ISA_ONE  = 2'd1,
    ISA_ZERO = 2'd2,
    ISA_ALL  = 2'd3
  } isa_sel_e;

  typedef struct packed {
    logic [THR_W-1:0]  thr;
    isa_sel_e          isa;
    logic              inv;
    logic              ren;
    logic              oen;
    logic [PRIV_N-1:0] pmask;
  } cfg_t;
endpackage

// File: rtl/qec_cfg_regs.sv
`timescale 1ns/1ps
module qec_cfg_regs
  import qec_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 2,
  parameter int MAX_INC   = 6,
  parameter bit SUP_RANGE = 1'b1,
  parameter bit SUP_OPC   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              cfg_q
);
  localparam logic [THR_W-1:0] THR_TOP = THR_W'(MAX_INC - 1);

  logic             sel;
  logic [THR_W-1:0] thr_in;
  logic             ren_in;
  logic             oen_in;
  logic             unused_cfg_bits;

  assign sel             = wr_en && (wr_addr == ADDR_W'(REG_CFG));
  assign thr_in          = wr_data[THR_LSB +: THR_W];
  assign unused_cfg_bits = ^wr_data;

  // qualifiers the event cannot use are tied off
  generate
    if (SUP_RANGE) begin : g_range
      assign ren_in = wr_data[REN_BIT];
    end else begin : g_no_range
      assign ren_in = 1'b0;
    end
    if (SUP_OPC) begin : g_opc
      assign oen_in = wr_data[OEN_BIT];
    end else begin : g_no_opc
      assign oen_in = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{thr: '0, isa: ISA_ANY, inv: 1'b0, ren: 1'b0, oen: 1'b0, pmask: '1};
    end else if (sel) begin
      cfg_q.thr   <= (thr_in > THR_TOP) ? THR_TOP : thr_in;
      cfg_q.isa   <= isa_sel_e'(wr_data[ISA_LSB +: 2]);
      cfg_q.inv   <= wr_data[INV_BIT];
      cfg_q.ren   <= ren_in;
      cfg_q.oen   <= oen_in;
      cfg_q.pmask <= wr_data[PM_LSB +: PRIV_N];
    end
  end
endmodule

// File: rtl/qec_qualify.sv
`timescale 1ns/1ps
module qec_qualify
  import qec_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  isa_sel_e          isa_sel,
  input  logic              inv,
  input  logic              ren,
  input  logic              oen,
  input  logic [PRIV_N-1:0] pmask,
  input  logic              freeze,
  input  logic              isa_mode,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              range_hit,
  input  logic              opc_hit,
  output logic              qual
);
  logic isa_ok, priv_ok, range_ok, opc_ok;

  always_comb begin
    unique case (isa_sel)
      ISA_ONE:  isa_ok = isa_mode;
      ISA_ZERO: isa_ok = !isa_mode;
      default:  isa_ok = 1'b1;
    endcase
  end

  assign priv_ok  = pmask[priv_lvl];
  assign range_ok = !ren || (range_hit ^ inv);
  assign opc_ok   = !oen || opc_hit;
  assign qual     = !freeze && isa_ok && priv_ok && range_ok && opc_ok;
endmodule

// File: rtl/qec_accum.sv
`timescale 1ns/1ps
module qec_accum
  import qec_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int MAX_INC = 6,
  localparam int INC_W  = $clog2(MAX_INC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual,
  input  logic [INC_W-1:0] evt_cnt,
  input  logic [THR_W-1:0] thr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_flag,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             irq_q
);
  logic [INC_W-1:0] evt_eff;
  logic [THR_W-1:0] evt_wide;
  logic [INC_W-1:0] step;
  logic [CNT_W:0]   sum;

  assign evt_eff  = (evt_cnt > INC_W'(MAX_INC)) ? INC_W'(MAX_INC) : evt_cnt;
  assign evt_wide = THR_W'(evt_eff);
  assign step     = (thr == '0) ? evt_eff
                  : ((evt_wide > thr) ? INC_W'(1) : '0);
  assign sum      = {1'b0, cnt_q} + (CNT_W+1)'(step);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (clr_flag) flag_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (qual) begin
        cnt_q <= sum[CNT_W-1:0];
        if (sum[CNT_W]) begin
          flag_q <= 1'b1;
          irq_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qec_top.sv
`timescale 1ns/1ps
module qec_top
  import qec_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int ADDR_W    = 2,
  parameter int MAX_INC   = 6,
  parameter bit SUP_RANGE = 1'b1,
  parameter bit SUP_OPC   = 1'b1,
  localparam int INC_W    = $clog2(MAX_INC + 1),
  localparam int PRIV_W   = $clog2(PRIV_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              freeze,
  input  logic [INC_W-1:0]  evt_cnt,
  input  logic              isa_mode,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              range_hit,
  input  logic              opc_hit,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  cfg_t cfg_q;
  logic qual, load, clr_flag;

  assign load     = wr_en && (wr_addr == ADDR_W'(REG_CNT));
  assign clr_flag = wr_en && (wr_addr == ADDR_W'(REG_CLR));

  qec_cfg_regs #(
    .DATA_W(CNT_W), .ADDR_W(ADDR_W), .MAX_INC(MAX_INC),
    .SUP_RANGE(SUP_RANGE), .SUP_OPC(SUP_OPC)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q)
  );

  qec_qualify #(.PRIV_W(PRIV_W)) u_qual (
    .isa_sel(cfg_q.isa), .inv(cfg_q.inv), .ren(cfg_q.ren), .oen(cfg_q.oen),
    .pmask(cfg_q.pmask), .freeze(freeze), .isa_mode(isa_mode),
    .priv_lvl(priv_lvl), .range_hit(range_hit), .opc_hit(opc_hit),
    .qual(qual)
  );

  qec_accum #(.CNT_W(CNT_W), .MAX_INC(MAX_INC)) u_acc (
    .clk(clk), .rst(rst), .qual(qual), .evt_cnt(evt_cnt), .thr(cfg_q.thr),
    .load(load), .load_val(wr_data), .clr_flag(clr_flag),
    .cnt_q(cnt), .flag_q(ovf_flag), .irq_q(ovf_irq)
  );
endmodule

// File: rtl/qec_chk.sv
`timescale 1ns/1ps
module qec_chk
  import qec_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 2,
  parameter int MAX_INC = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              freeze,
  input logic              isa_mode,
  input logic [THR_W-1:0]  thr,
  input isa_sel_e          isa_sel,
  input logic [CNT_W-1:0]  cnt,
  input logic              ovf_flag,
  input logic              ovf_irq
);
  logic load;
  assign load = wr_en && (wr_addr == ADDR_W'(REG_CNT));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (freeze && !load) |=> (cnt == $past(cnt)));

  // R3
  thr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (thr != '0 && !load) |=> ((cnt - $past(cnt)) <= CNT_W'(1)));

  // R5
  step_max_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((cnt - $past(cnt)) <= CNT_W'(MAX_INC)));

  // R6
  isa_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && ((isa_sel == ISA_ONE && !isa_mode) || (isa_sel == ISA_ZERO && isa_mode)))
      |=> (cnt == $past(cnt)));

  // R4
  thr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    thr <= THR_W'(MAX_INC - 1));

  // R13
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> ovf_flag);

  // R13
  irq_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (cnt < $past(cnt)));
endmodule

bind qec_top qec_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MAX_INC(MAX_INC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .freeze(freeze),
  .isa_mode(isa_mode), .thr(cfg_q.thr), .isa_sel(cfg_q.isa), .cnt(cnt),
  .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
);

// File: tb/test_qec_top.sv
`timescale 1ns/1ps
module test_qec_top;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        freeze = 1'b0, isa_mode = 1'b0, range_hit = 1'b0, opc_hit = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic [2:0]  evt = '0;
  logic        evt1 = 1'b0;
  logic [63:0] cnt, cnt_l;
  logic        flag, irq, flag_l, irq_l;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  qec_top i_qec_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freeze(freeze), .evt_cnt(evt), .isa_mode(isa_mode), .priv_lvl(priv_lvl),
    .range_hit(range_hit), .opc_hit(opc_hit), .cnt(cnt), .ovf_flag(flag), .ovf_irq(irq)
  );

  qec_top #(.MAX_INC(1), .SUP_RANGE(1'b0), .SUP_OPC(1'b0)) i_qec_top_lim (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freeze(freeze), .evt_cnt(evt1), .isa_mode(isa_mode), .priv_lvl(priv_lvl),
    .range_hit(range_hit), .opc_hit(opc_hit), .cnt(cnt_l), .ovf_flag(flag_l), .ovf_irq(irq_l)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(int thr, int isa, bit inv, bit ren, bit oen, int pm);
    logic [63:0] w = '0;
    w[7:0]   = 8'(thr);
    w[9:8]   = 2'(isa);
    w[10]    = inv;
    w[11]    = ren;
    w[12]    = oen;
    w[19:16] = 4'(pm);
    return w;
  endfunction

  // entered and left on a falling edge
  task automatic wr(int addr, logic [63:0] data);
    wr_en = 1'b1; wr_addr = 2'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic dstep(string tag, int c, bit im, int pl, bit rh, bit oh, bit fz, logic [63:0] exp);
    logic [63:0] b;
    b = cnt;
    evt = 3'(c); isa_mode = im; priv_lvl = 2'(pl); range_hit = rh; opc_hit = oh; freeze = fz;
    @(negedge clk);
    chk(tag, cnt - b, exp);
    evt = '0; isa_mode = 1'b0; priv_lvl = '0; range_hit = 1'b0; opc_hit = 1'b0; freeze = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cnt", cnt, 0);
    chk("R1 flag", {63'b0, flag}, 0);
    chk("R1 irq", {63'b0, irq}, 0);
    dstep("R1 default cfg counts", 4, 1'b1, 3, 1'b0, 1'b0, 1'b0, 4);

    // R2 and R5: threshold zero adds the full count, clamped at MAX_INC
    wr(0, mk(0, 0, 0, 0, 0, 15));
    for (int c = 0; c < 8; c++)
      dstep(c < 7 ? "R2 full add" : "R5 clamp", c, 1'b0, 0, 1'b0, 1'b0, 1'b0, (c > 6) ? 6 : c);

    // R3: thresholds 1..5
    for (int t = 1; t < 6; t++) begin
      wr(0, mk(t, 0, 0, 0, 0, 15));
      for (int c = 0; c < 8; c++)
        dstep("R3 thresh", c, 1'b0, 0, 1'b0, 1'b0, 1'b0, (((c > 6) ? 6 : c) > t) ? 1 : 0);
    end

    // R4: oversize thresholds saturate to 5
    wr(0, mk(9, 0, 0, 0, 0, 15));
    dstep("R4 sat c5", 5, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
    dstep("R4 sat c6", 6, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1);
    wr(0, mk(200, 0, 0, 0, 0, 15));
    dstep("R4 sat200", 6, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1);

    // R6: mode selector
    for (int s = 0; s < 4; s++) begin
      wr(0, mk(0, s, 0, 0, 0, 15));
      for (int m = 0; m < 2; m++)
        dstep("R6 isa", 3, 1'(m), 0, 1'b0, 1'b0, 1'b0,
              ((s == 1 && m == 0) || (s == 2 && m == 1)) ? 0 : 3);
    end

    // R7: privilege mask
    for (int pm = 0; pm < 16; pm++) begin
      wr(0, mk(0, 0, 0, 0, 0, pm));
      for (int l = 0; l < 4; l++)
        dstep("R7 priv", 2, 1'b0, l, 1'b0, 1'b0, 1'b0, ((pm >> l) & 1) ? 2 : 0);
    end

    // R8: range enable, invert, hit
    for (int k = 0; k < 8; k++) begin
      wr(0, mk(0, 0, 1'(k >> 1), 1'(k >> 2), 0, 15));
      dstep("R8 range", 4, 1'b0, 0, 1'(k), 1'b0, 1'b0,
            ((k >> 2) == 0 || (((k & 1) ^ ((k >> 1) & 1)) == 1)) ? 4 : 0);
    end

    // R9: opcode enable and hit
    for (int k = 0; k < 4; k++) begin
      wr(0, mk(0, 0, 0, 0, 1'(k >> 1), 15));
      dstep("R9 opc", 5, 1'b0, 0, 1'b0, 1'(k), 1'b0, ((k >> 1) == 0 || (k & 1) == 1) ? 5 : 0);
    end

    // R10: freeze
    wr(0, mk(0, 0, 0, 0, 0, 15));
    dstep("R10 frozen", 6, 1'b0, 0, 1'b0, 1'b0, 1'b1, 0);
    dstep("R10 thawed", 6, 1'b0, 0, 1'b0, 1'b0, 1'b0, 6);

    // R11: the write cycle uses the old configuration
    begin
      logic [63:0] b;
      b = cnt;
      evt = 3'd3; isa_mode = 1'b0;
      wr(0, mk(0, 1, 0, 0, 0, 15));
      chk("R11 old cfg", cnt - b, 3);
      evt = '0;
      dstep("R11 new cfg", 3, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
    end
    wr(0, mk(0, 0, 0, 0, 0, 15));

    // R12: preload, with priority over accumulation
    wr(1, 64'h1234);
    chk("R12 load", cnt, 64'h1234);
    evt = 3'd4;
    wr(1, 64'd500);
    evt = '0;
    chk("R12 load wins", cnt, 64'd500);

    // R13: wrap sets flag and pulses irq once
    wr(1, 64'hFFFF_FFFF_FFFF_FFFD);
    chk("R13 no irq before", {63'b0, irq}, 0);
    evt = 3'd5;
    @(negedge clk);
    evt = '0;
    chk("R13 wrap value", cnt, 2);
    chk("R13 irq", {63'b0, irq}, 1);
    chk("R13 flag", {63'b0, flag}, 1);
    @(negedge clk);
    chk("R13 irq one cycle", {63'b0, irq}, 0);
    chk("R13 flag sticky", {63'b0, flag}, 1);
    wr(2, 64'd0);
    chk("R13 flag clear", {63'b0, flag}, 0);

    // R14: limited instance ignores range/opcode enables, threshold forced to 0
    wr(0, mk(3, 0, 1, 1, 1, 15));
    begin
      logic [63:0] b;
      b = cnt_l;
      evt1 = 1'b1; range_hit = 1'b1; opc_hit = 1'b0;
      @(negedge clk);
      chk("R14 ignored quals", cnt_l - b, 1);
      evt1 = 1'b0;
      b = cnt_l;
      @(negedge clk);
      chk("R14 idle", cnt_l - b, 0);
      range_hit = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule